// File: doc/BRIEF.md
# Lazy-Optimistic Transaction Sequencer

This block steers one hardware memory transaction on a core that buffers its transactional stores in the cache and checks for conflicts only when it commits. When the core starts a transaction, the block saves a register checkpoint, clears the read and write tracking bits, and remembers the handler address for the abort path. While the transaction runs, it watches for conflicts from other cores' commits, evictions of tracked lines, and an explicit abort from software.

On a commit request the block takes a snapshot of the write-set slot mask from the line tracker. It then requests exclusive ownership of each marked slot in turn, and waits for a grant on every request. When the last grant arrives, one commit cycle clears all tracking bits at once and turns the buffered lines into valid dirty data. A transaction that loses a conflict gets a single abort cycle instead. That cycle invalidates the buffered lines, clears the tracking bits, restores the checkpoint, and raises a fallback strobe carrying the handler address and an abort cause.

Top module: `txn_commit_ctrl`

## Requirements
- R1: `begin_i` seen while idle raises `ckpt_save_o` and `gang_clr_o` in the same cycle, and `in_txn_o` is high from the next cycle.
- R2: `begin_i` seen while a transaction is in progress has no effect: `ckpt_save_o` stays low and the transaction goes on.
- R3: After `end_i` is accepted, `upg_req_o` is raised once for each set bit of the `wset_mask_i` snapshot taken at acceptance, in ascending slot order, with the slot number on `upg_idx_o`.
- R4: While `upg_req_o` is high and `upg_gnt_i` is low, `upg_idx_o` holds its value. The walk moves to the next slot only in the cycle after a grant.
- R5: The cycle after the final grant, or the cycle after a one-cycle validation when the snapshot is zero, is a single commit cycle. In that cycle `publish_o`, `done_o` and `gang_clr_o` are high and `wset_inv_o` is low.
- R6: A conflict, eviction or explicit abort while the transaction is active leads, the next cycle, to a single abort cycle. In that cycle `wset_inv_o`, `gang_clr_o`, `ckpt_restore_o` and `fallback_o` are high, and `fallback_addr_o` equals the `handler_i` value captured at begin.
- R7: During validation, `conflict_i` or `evict_i` aborts the transaction even if a grant arrives in the same cycle. `abort_req_i` is ignored during validation.
- R8: `abort_cause_o` is valid with `fallback_o`: 1 means conflict, 2 means eviction, 3 means explicit. When several are raised together, conflict wins over eviction, and eviction wins over explicit.
- R9: Conflict, eviction, abort and commit indications have no effect while idle or in the commit cycle. A commit cycle always completes.
- R10: `done_o` and `fallback_o` are never high together, and `upg_req_o` is high only while a transaction is in progress.
- R11: After reset, `in_txn_o`, `upg_req_o`, `done_o` and `fallback_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| begin_i | input | 1 | Start a transaction |
| handler_i | input | PC_W | Abort handler address, captured at begin |
| end_i | input | 1 | Request commit |
| abort_req_i | input | 1 | Explicit software abort |
| conflict_i | input | 1 | Another core's commit hit the read or write set |
| evict_i | input | 1 | A tracked line was evicted |
| wset_mask_i | input | N_LINES | Write-set slot mask from the tracker |
| upg_gnt_i | input | 1 | Exclusive ownership granted for the current slot |
| in_txn_o | output | 1 | Transaction in progress |
| ckpt_save_o | output | 1 | Save register checkpoint |
| ckpt_restore_o | output | 1 | Restore register checkpoint |
| upg_req_o | output | 1 | Exclusive upgrade request |
| upg_idx_o | output | IDX_W | Slot being upgraded |
| gang_clr_o | output | 1 | Clear all read/write tracking bits |
| publish_o | output | 1 | Turn buffered lines into valid dirty data |
| wset_inv_o | output | 1 | Invalidate buffered write-set lines |
| done_o | output | 1 | Commit complete strobe |
| fallback_o | output | 1 | Abort strobe, resume at handler |
| fallback_addr_o | output | PC_W | Handler address |
| abort_cause_o | output | 2 | Abort reason code |

## Verification
The assertions assume two things about the inputs. First, the tracker's grant only answers a pending request. Second, the write-set mask is stable only when it is sampled, at the moment `end_i` is accepted. The bench drives `upg_gnt_i` only while it sees `upg_req_o` high, and presents each mask together with `end_i`. The bench drives conflicts only in chosen cycles, so that the expected state on every following cycle is known. That includes conflicts that coincide with a grant, and conflicts in the commit cycle.

// File: rtl/txn_pkg.sv
package txn_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ACTIVE   = 3'd1,
    ST_VALIDATE = 3'd2,
    ST_COMMIT   = 3'd3,
    ST_ABORT    = 3'd4
  } txn_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_CONFLICT = 2'd1,
    CAUSE_EVICT    = 2'd2,
    CAUSE_EXPLICIT = 2'd3
  } abort_cause_e;

  function automatic abort_cause_e pick_cause(input logic c, input logic e, input logic x);
    if (c)      return CAUSE_CONFLICT;
    else if (e) return CAUSE_EVICT;
    else if (x) return CAUSE_EXPLICIT;
    else        return CAUSE_NONE;
  endfunction
endpackage

// File: rtl/txn_fsm.sv
module txn_fsm
  import txn_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         begin_i,
  input  logic         end_i,
  input  logic         abort_req_i,
  input  logic         conflict_i,
  input  logic         evict_i,
  input  logic         walk_last_i,
  output txn_state_e   state_o,
  output logic         abort_hit_o,
  output logic         accept_begin_o,
  output logic         accept_end_o,
  output abort_cause_e cause_o
);
  txn_state_e state_q, state_d;
  logic hit_act, hit_val;

  always_comb begin
    hit_act     = (state_q == ST_ACTIVE) && (conflict_i || evict_i || abort_req_i);
    // explicit abort is ignored once validation has started
    hit_val     = (state_q == ST_VALIDATE) && (conflict_i || evict_i);
    abort_hit_o = hit_act || hit_val;
    cause_o     = pick_cause(conflict_i, evict_i, abort_req_i && (state_q == ST_ACTIVE));
    accept_begin_o = (state_q == ST_IDLE) && begin_i;
    accept_end_o   = (state_q == ST_ACTIVE) && end_i && !hit_act;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (begin_i) state_d = ST_ACTIVE;
      ST_ACTIVE:   if (hit_act) state_d = ST_ABORT;
                   else if (end_i) state_d = ST_VALIDATE;
      ST_VALIDATE: if (hit_val) state_d = ST_ABORT;
                   else if (walk_last_i) state_d = ST_COMMIT;
      ST_COMMIT:   state_d = ST_IDLE;
      ST_ABORT:    state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  assert_begin_enters_active_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_begin_o |=> state_q == ST_ACTIVE);

  assert_commit_after_validate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_COMMIT |-> $past(state_q) == ST_VALIDATE);

  assert_abort_single_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ABORT |=> state_q == ST_IDLE);

  assert_validate_hit_aborts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_VALIDATE && (conflict_i || evict_i)) |=> state_q == ST_ABORT);
endmodule

// File: rtl/txn_wset_walker.sv
module txn_wset_walker #(
  parameter int N_LINES = 8,
  localparam int IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic               run_i,
  input  logic               gnt_i,
  output logic               req_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               last_o
);
  logic [N_LINES-1:0] pend_q, sel_oh, pend_after;

  // lowest pending slot first
  always_comb begin
    idx_o  = '0;
    sel_oh = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        idx_o  = IDX_W'(i);
        sel_oh = N_LINES'(1) << i;
      end
    end
  end

  assign req_o      = run_i && (pend_q != '0);
  assign pend_after = (req_o && gnt_i) ? (pend_q & ~sel_oh) : pend_q;
  assign last_o     = run_i && (pend_after == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= '0;
    else if (load_i) pend_q <= mask_i;
    else if (run_i)  pend_q <= pend_after;
    else             pend_q <= '0;
  end

  assert_idx_held_without_grant_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i && run_i) |=> (!run_i || (req_o && $stable(idx_o))));

  assert_walk_ascending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && gnt_i) |=> (!run_i || !req_o || (idx_o > $past(idx_o))));
endmodule

// File: rtl/txn_abort_ctx.sv
module txn_abort_ctx
  import txn_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            capture_i,
  input  logic [PC_W-1:0] handler_i,
  input  logic            abort_hit_i,
  input  abort_cause_e    cause_i,
  output logic [PC_W-1:0] handler_o,
  output abort_cause_e    cause_o
);
  logic [PC_W-1:0] handler_q;
  abort_cause_e    cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      handler_q <= '0;
      cause_q   <= CAUSE_NONE;
    end else begin
      if (capture_i)   handler_q <= handler_i;
      if (capture_i)   cause_q   <= CAUSE_NONE;
      else if (abort_hit_i) cause_q <= cause_i;
    end
  end

  assign handler_o = handler_q;
  assign cause_o   = cause_q;

  assert_cause_known_on_abort_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_hit_i |=> cause_q != CAUSE_NONE);
endmodule

// File: rtl/txn_commit_ctrl.sv
module txn_commit_ctrl
  import txn_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int PC_W    = 32,
  localparam int IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               begin_i,
  input  logic [PC_W-1:0]    handler_i,
  input  logic               end_i,
  input  logic               abort_req_i,
  input  logic               conflict_i,
  input  logic               evict_i,
  input  logic [N_LINES-1:0] wset_mask_i,
  input  logic               upg_gnt_i,
  output logic               in_txn_o,
  output logic               ckpt_save_o,
  output logic               ckpt_restore_o,
  output logic               upg_req_o,
  output logic [IDX_W-1:0]   upg_idx_o,
  output logic               gang_clr_o,
  output logic               publish_o,
  output logic               wset_inv_o,
  output logic               done_o,
  output logic               fallback_o,
  output logic [PC_W-1:0]    fallback_addr_o,
  output logic [1:0]         abort_cause_o
);
  txn_state_e   state;
  abort_cause_e hit_cause, held_cause;
  logic abort_hit, acc_begin, acc_end, walk_last, run;

  txn_fsm u_fsm (
    .clk_i, .rst_ni, .begin_i, .end_i, .abort_req_i, .conflict_i, .evict_i,
    .walk_last_i    (walk_last),
    .state_o        (state),
    .abort_hit_o    (abort_hit),
    .accept_begin_o (acc_begin),
    .accept_end_o   (acc_end),
    .cause_o        (hit_cause)
  );

  assign run = (state == ST_VALIDATE);

  txn_wset_walker #(.N_LINES(N_LINES)) u_walk (
    .clk_i, .rst_ni,
    .load_i (acc_end),
    .mask_i (wset_mask_i),
    .run_i  (run),
    .gnt_i  (upg_gnt_i),
    .req_o  (upg_req_o),
    .idx_o  (upg_idx_o),
    .last_o (walk_last)
  );

  txn_abort_ctx #(.PC_W(PC_W)) u_ctx (
    .clk_i, .rst_ni,
    .capture_i   (acc_begin),
    .handler_i   (handler_i),
    .abort_hit_i (abort_hit),
    .cause_i     (hit_cause),
    .handler_o   (fallback_addr_o),
    .cause_o     (held_cause)
  );

  assign in_txn_o       = (state != ST_IDLE);
  assign ckpt_save_o    = acc_begin;
  assign publish_o      = (state == ST_COMMIT);
  assign done_o         = (state == ST_COMMIT);
  assign fallback_o     = (state == ST_ABORT);
  assign wset_inv_o     = (state == ST_ABORT);
  assign ckpt_restore_o = (state == ST_ABORT);
  assign gang_clr_o     = acc_begin || (state == ST_COMMIT) || (state == ST_ABORT);
  assign abort_cause_o  = held_cause;

  assert_req_inside_txn_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upg_req_o |-> in_txn_o);

  assert_done_fallback_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fallback_o));
endmodule

// File: tb/tb_txn_commit_ctrl.sv
module tb_txn_commit_ctrl;
  localparam int N = 8;
  localparam int PW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic begin_r, end_r, abrt_r, conf_r, evict_r, gnt_r;
  logic [PW-1:0] handler_r;
  logic [N-1:0]  mask_r;
  logic in_txn, save, restore, req, gclr, pub, inv, done, fb;
  logic [2:0] idx;
  logic [PW-1:0] fb_addr;
  logic [1:0] cause;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  txn_commit_ctrl #(.N_LINES(N), .PC_W(PW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .begin_i(begin_r), .handler_i(handler_r),
    .end_i(end_r), .abort_req_i(abrt_r), .conflict_i(conf_r), .evict_i(evict_r),
    .wset_mask_i(mask_r), .upg_gnt_i(gnt_r), .in_txn_o(in_txn), .ckpt_save_o(save),
    .ckpt_restore_o(restore), .upg_req_o(req), .upg_idx_o(idx), .gang_clr_o(gclr),
    .publish_o(pub), .wset_inv_o(inv), .done_o(done), .fallback_o(fb),
    .fallback_addr_o(fb_addr), .abort_cause_o(cause)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clr_in();
    begin_r = 0; end_r = 0; abrt_r = 0; conf_r = 0; evict_r = 0; gnt_r = 0;
    mask_r = '0;
  endtask

  // advance to next negedge, inputs cleared, settle
  task automatic step();
    @(negedge clk);
    clr_in();
    #1;
  endtask

  task automatic start_txn(input logic [PW-1:0] h);
    step();
    begin_r = 1; handler_r = h; #1;
    chk("R1 ckpt_save on begin", save, 1);
    chk("R1 gang_clr on begin", gclr, 1);
    step();
    chk("R1 in_txn after begin", in_txn, 1);
  endtask

  task automatic t_reset();
    chk("R11 in_txn", in_txn, 0);
    chk("R11 upg_req", req, 0);
    chk("R11 done", done, 0);
    chk("R11 fallback", fb, 0);
  endtask

  task automatic t_commit_walk();
    start_txn(32'h0000_0400);
    begin_r = 1; #1;
    chk("R2 no save when busy", save, 0);
    end_r = 1; mask_r = 8'b1010_0100; #1;
    chk("R3 no req before validate", req, 0);
    step();
    chk("R2 still in txn", in_txn, 1);
    chk("R3 req slot2", req, 1);
    chk("R3 idx slot2", idx, 2);
    step();
    chk("R4 idx held", idx, 2);
    gnt_r = 1; #1;
    step();
    chk("R3 idx slot5", idx, 5);
    gnt_r = 1; #1;
    step();
    chk("R3 idx slot7", idx, 7);
    chk("R5 no early done", done, 0);
    gnt_r = 1; #1;
    step();
    chk("R5 publish", pub, 1);
    chk("R5 done", done, 1);
    chk("R5 gang_clr", gclr, 1);
    chk("R5 no inv", inv, 0);
    chk("R10 no fallback at done", fb, 0);
    conf_r = 1; evict_r = 1; #1;
    step();
    chk("R9 commit completes", in_txn, 0);
    chk("R9 no fallback after commit", fb, 0);
  endtask

  task automatic t_empty_commit();
    start_txn(32'h0000_0800);
    end_r = 1; mask_r = '0; #1;
    step();
    chk("R5 empty no req", req, 0);
    abrt_r = 1; #1;
    step();
    chk("R7 abort_req ignored in validate", fb, 0);
    chk("R5 empty commit done", done, 1);
    step();
    chk("R5 back idle", in_txn, 0);
  endtask

  task automatic t_abort(input logic c, input logic e, input logic x,
                         input logic [1:0] exp_cause, input logic [PW-1:0] h);
    start_txn(h);
    conf_r = c; evict_r = e; abrt_r = x; #1;
    step();
    chk("R6 fallback", fb, 1);
    chk("R6 wset_inv", inv, 1);
    chk("R6 restore", restore, 1);
    chk("R6 gang_clr", gclr, 1);
    chk("R6 handler addr", fb_addr, h);
    chk("R8 cause", cause, exp_cause);
    chk("R10 no done on abort", done, 0);
    step();
    chk("R6 fallback one cycle", fb, 0);
    chk("R6 idle after abort", in_txn, 0);
  endtask

  task automatic t_validate_evict();
    start_txn(32'h0000_1230);
    end_r = 1; mask_r = 8'b0000_0011; #1;
    step();
    chk("R3 idx slot0", idx, 0);
    gnt_r = 1; evict_r = 1; #1;
    step();
    chk("R7 abort beats grant", fb, 1);
    chk("R7 no done", done, 0);
    chk("R8 evict cause", cause, 2);
    step();
    chk("R7 idle", in_txn, 0);
    chk("R10 no req idle", req, 0);
  endtask

  task automatic t_idle_ignore();
    step();
    conf_r = 1; evict_r = 1; abrt_r = 1; end_r = 1; mask_r = 8'hff; #1;
    step();
    chk("R9 idle in_txn", in_txn, 0);
    chk("R9 idle no req", req, 0);
    chk("R9 idle no fallback", fb, 0);
  endtask

  initial begin
    clr_in(); handler_r = '0;
    #35 rst_n = 1;
    step();
    t_reset();
    t_commit_walk();
    t_empty_commit();
    t_abort(1, 0, 0, 2'd1, 32'h0000_1234);
    t_abort(0, 0, 1, 2'd3, 32'h0000_2000);
    t_abort(0, 1, 1, 2'd2, 32'h0000_3000);
    t_abort(1, 1, 1, 2'd1, 32'h0000_4000);
    t_validate_evict();
    t_idle_ignore();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule